// File: doc/BRIEF.md
# Three-Level Discharge Overcurrent Detector

This block watches the current-sense pin of a battery pack through two sampled digital codes and decides when the discharge current has become dangerous. The first code measures how far the sense pin has dropped below the positive rail. The second code measures how high the sense pin sits above the negative rail. The block checks three thresholds at the same time:

- Level 1 is a configurable threshold with a configurable delay.
- Level 2 is a fixed threshold with a fixed, shorter delay.
- Level 3 is a short-circuit threshold, referenced to the negative rail, with the shortest fixed delay.

Each level must hold for its own number of sample ticks before it counts. When any level has held long enough, a single trip flag is latched. The trip flag removes the permission for both the charge switch and the discharge switch. A code records which level fired.

Detection is armed only while the surrounding supervisor reports that the pack is in its normal discharging state. The supervisor also supplies the timebase tick. Once tripped, the flag stays set until the load has gone away. The block recognises this when the drop below the positive rail returns to the release threshold or less. The release threshold is the level-1 threshold, or the effective level-2 threshold when level 1 is inhibited. The effective level-2 threshold is always held strictly above the level-1 threshold. This keeps level 2 the higher trip point even when level 1 is configured near the top of its range.

Top module: `dschg_ocp_monitor`

## Requirements
- R1: After reset, `oc_trip` is 0, `trip_level` is 0, and both `chg_allow` and `dsg_allow` are 1.
- R2: Level 1 qualifies while `drop_code >= l1_thr_code` and `l1_inhibit` is 0. It trips on the clock edge at which it has qualified on `l1_dly_ticks` consecutive ticks. A delay value of 0 acts as 1.
- R3: Level 2 qualifies while `drop_code` is at or above the effective level-2 threshold. It trips after `L2_DLY` consecutive qualifying ticks.
- R4: Level 3 qualifies while `rail_code <= L3_THR`. It trips after `L3_DLY` consecutive qualifying ticks.
- R5: A level's tick count restarts from zero whenever that level fails to qualify on any clock cycle.
- R6: A trip sets `oc_trip` to 1 and drives both `chg_allow` and `dsg_allow` to 0. It also sets `trip_level` to the firing level, encoded as 1, 2 or 3. If several levels expire on the same edge, the highest-numbered level is recorded.
- R7: While tripped, the flag and `trip_level` hold. On the edge after `drop_code` is at or below the release threshold, both clear to 0.
- R8: While `l1_inhibit` is 1, level 1 never trips, and the release threshold is the effective level-2 threshold instead of `l1_thr_code`.
- R9: The effective level-2 threshold is `L2_THR` when `L2_THR > l1_thr_code`, and `l1_thr_code + 1` otherwise. This keeps it strictly above level 1.
- R10: While `arm_normal` is 0, no level counts and no trip occurs. Dropping `arm_normal` part-way through a count restarts that count.
- R11: Tick counts advance only on cycles where `tick` is 1. A qualifying level with `tick` held at 0 never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; counts advance only when high |
| drop_code | input | CODE_W | Sense-pin drop below the positive rail, unsigned code |
| rail_code | input | CODE_W | Sense-pin height above the negative rail, unsigned code |
| l1_thr_code | input | CODE_W | Level-1 threshold code |
| l1_dly_ticks | input | DLY_W | Level-1 qualification delay in ticks |
| l1_inhibit | input | 1 | Disables level 1 and moves release to the level-2 threshold |
| arm_normal | input | 1 | Pack is in normal discharging state; arms detection |
| oc_trip | output | 1 | Latched overcurrent trip flag |
| trip_level | output | 2 | Level that caused the trip (0 none, 1, 2, 3) |
| chg_allow | output | 1 | Permission for the charge switch |
| dsg_allow | output | 1 | Permission for the discharge switch |

## Verification
The hardest situation to reach is the one where level 1 is configured at or above the fixed level-2 threshold. In that case only the floor rule decides which level fires. The stimulus places the drop exactly at the raised level-1 setting. Level 1 must then win after its long delay, even though the plain level-2 constant would have fired much earlier. One code higher, level 2 must fire after its short delay. A second awkward case is the one-cycle dip below threshold partway through a long count. The bench also drives it, so that an adder that fails to restart would trip early.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    TRIP_NONE = 2'd0,
    TRIP_L1   = 2'd1,
    TRIP_L2   = 2'd2,
    TRIP_L3   = 2'd3
  } trip_code_e;

  localparam int unsigned NUM_LEVELS = 3;

  // Highest-numbered expiring level wins
  function automatic trip_code_e pick_level(input logic [NUM_LEVELS-1:0] exp_vec);
    trip_code_e code;
    code = TRIP_NONE;
    if (exp_vec[2])      code = TRIP_L3;
    else if (exp_vec[1]) code = TRIP_L2;
    else if (exp_vec[0]) code = TRIP_L1;
    return code;
  endfunction

endpackage

// File: rtl/ocp_thresholds.sv
module ocp_thresholds #(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned L2_THR = 120,
  parameter int unsigned L3_THR = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] drop_code,
  input  logic [CODE_W-1:0] rail_code,
  input  logic [CODE_W-1:0] l1_thr_code,
  input  logic              l1_inhibit,
  output logic [2:0]        hit,
  output logic              release_ok
);
  localparam int unsigned EXT_W = CODE_W + 1;
  localparam logic [EXT_W-1:0] L2_CONST = EXT_W'(L2_THR);
  localparam logic [CODE_W-1:0] L3_CONST = CODE_W'(L3_THR);

  logic [EXT_W-1:0] l1_ext;
  logic [EXT_W-1:0] drop_ext;
  logic [EXT_W-1:0] l2_eff;
  logic [EXT_W-1:0] rel_thr;

  always_comb begin
    l1_ext   = {1'b0, l1_thr_code};
    drop_ext = {1'b0, drop_code};
    // floor level 2 one code above level 1
    if (L2_CONST > l1_ext) l2_eff = L2_CONST;
    else                   l2_eff = l1_ext + EXT_W'(1);
    rel_thr    = l1_inhibit ? l2_eff : l1_ext;
    hit[0]     = !l1_inhibit && (drop_ext >= l1_ext);
    hit[1]     = drop_ext >= l2_eff;
    hit[2]     = rail_code <= L3_CONST;
    release_ok = drop_ext <= rel_thr;
  end

  AST_L2_ABOVE_L1: assert property (@(posedge clk) disable iff (!rst_n)
    l2_eff > l1_ext); // R9

endmodule

// File: rtl/ocp_delay_timer.sv
module ocp_delay_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             qual,
  input  logic [DLY_W-1:0] limit,
  output logic             expire
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             at_end;
  logic             cnt_en;

  always_comb begin
    at_end = ({1'b0, cnt_q} + (DLY_W+1)'(1)) >= {1'b0, limit};
    expire = qual && tick && at_end;
    cnt_en = !qual || (tick && !at_end);
    if (!qual) cnt_d = '0;
    else       cnt_d = cnt_q + DLY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (cnt_q == '0)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !tick) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch
  import ocp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] expire,
  input  logic                  release_ok,
  output logic                  oc_q,
  output trip_code_e            code_q
);
  logic       oc_d;
  trip_code_e code_d;
  logic       upd_en;

  always_comb begin
    oc_d   = oc_q;
    code_d = code_q;
    upd_en = 1'b0;
    if (oc_q) begin
      if (release_ok) begin
        oc_d   = 1'b0;
        code_d = TRIP_NONE;
        upd_en = 1'b1;
      end
    end else if (|expire) begin
      oc_d   = 1'b1;
      code_d = pick_level(expire);
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q   <= 1'b0;
      code_q <= TRIP_NONE;
    end else if (upd_en) begin
      oc_q   <= oc_d;
      code_q <= code_d;
    end
  end

  AST_CODE_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    oc_q == (code_q != TRIP_NONE)); // R6

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q && !release_ok) |=> (oc_q && $stable(code_q))); // R7

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q && release_ok) |=> !oc_q); // R7

endmodule

// File: rtl/dschg_ocp_monitor.sv
module dschg_ocp_monitor
  import ocp_pkg::*;
#(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned DLY_W  = 16,
  parameter int unsigned L2_THR = 120,
  parameter int unsigned L3_THR = 400,
  parameter int unsigned L2_DLY = 800,
  parameter int unsigned L3_DLY = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] drop_code,
  input  logic [CODE_W-1:0] rail_code,
  input  logic [CODE_W-1:0] l1_thr_code,
  input  logic [DLY_W-1:0]  l1_dly_ticks,
  input  logic              l1_inhibit,
  input  logic              arm_normal,
  output logic              oc_trip,
  output logic [1:0]        trip_level,
  output logic              chg_allow,
  output logic              dsg_allow
);
  localparam logic [DLY_W-1:0] L2_LIM = DLY_W'(L2_DLY);
  localparam logic [DLY_W-1:0] L3_LIM = DLY_W'(L3_DLY);

  logic [NUM_LEVELS-1:0] hit;
  logic [NUM_LEVELS-1:0] expire;
  logic [DLY_W-1:0]      lim [NUM_LEVELS];
  logic                  release_ok;
  logic                  armed;
  logic                  oc_q;
  trip_code_e            code_q;

  ocp_thresholds #(
    .CODE_W (CODE_W),
    .L2_THR (L2_THR),
    .L3_THR (L3_THR)
  ) u_thr (
    .clk         (clk),
    .rst_n       (rst_n),
    .drop_code   (drop_code),
    .rail_code   (rail_code),
    .l1_thr_code (l1_thr_code),
    .l1_inhibit  (l1_inhibit),
    .hit         (hit),
    .release_ok  (release_ok)
  );

  always_comb begin
    armed  = arm_normal && !oc_q;
    lim[0] = l1_dly_ticks;
    lim[1] = L2_LIM;
    lim[2] = L3_LIM;
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    ocp_delay_timer #(
      .DLY_W (DLY_W)
    ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .qual   (armed && hit[g]),
      .limit  (lim[g]),
      .expire (expire[g])
    );
  end

  ocp_trip_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .release_ok (release_ok),
    .oc_q       (oc_q),
    .code_q     (code_q)
  );

  always_comb begin
    oc_trip    = oc_q;
    trip_level = code_q;
    chg_allow  = !oc_q;
    dsg_allow  = !oc_q;
  end

  AST_NO_TRIP_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_normal && !oc_trip) |=> !oc_trip); // R10

  AST_NO_TRIP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !oc_trip) |=> !oc_trip); // R11

endmodule

// File: tb/dschg_ocp_monitor_bench.sv
module dschg_ocp_monitor_bench;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned DLY_W  = 16;
  localparam int unsigned L2_THR = 120;
  localparam int unsigned L3_THR = 400;
  localparam int unsigned L2_DLY = 8;
  localparam int unsigned L3_DLY = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tick;
  logic [CODE_W-1:0] drop_code;
  logic [CODE_W-1:0] rail_code;
  logic [CODE_W-1:0] l1_thr_code;
  logic [DLY_W-1:0]  l1_dly_ticks;
  logic              l1_inhibit;
  logic              arm_normal;
  logic              oc_trip;
  logic [1:0]        trip_level;
  logic              chg_allow;
  logic              dsg_allow;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dschg_ocp_monitor #(
    .CODE_W (CODE_W), .DLY_W (DLY_W), .L2_THR (L2_THR),
    .L3_THR (L3_THR), .L2_DLY (L2_DLY), .L3_DLY (L3_DLY)
  ) u_dschg_ocp_monitor (
    .clk (clk), .rst_n (rst_n), .tick (tick), .drop_code (drop_code),
    .rail_code (rail_code), .l1_thr_code (l1_thr_code),
    .l1_dly_ticks (l1_dly_ticks), .l1_inhibit (l1_inhibit),
    .arm_normal (arm_normal), .oc_trip (oc_trip), .trip_level (trip_level),
    .chg_allow (chg_allow), .dsg_allow (dsg_allow)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(input logic exp_oc, input logic [1:0] exp_lvl, input string req);
    logic [4:0] act, exp;
    act = {oc_trip, trip_level, chg_allow, dsg_allow};
    exp = {exp_oc, exp_lvl, !exp_oc, !exp_oc};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {oc,lvl,chg,dsg} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle_idle();
    drop_code = 0; rail_code = 700;
    step(2);
  endtask

  task automatic t_reset();
    expect_state(1'b0, 2'd0, "R1 reset");
  endtask

  task automatic t_level1();
    drop_code = 60;
    step(19); expect_state(1'b0, 2'd0, "R2 l1 before delay");
    step(1);  expect_state(1'b1, 2'd1, "R2 R6 l1 trip");
    drop_code = 61;
    step(3);  expect_state(1'b1, 2'd1, "R7 hold above release");
    drop_code = 60;
    step(1);  expect_state(1'b0, 2'd0, "R7 release at threshold");
    settle_idle();
  endtask

  task automatic t_l1_gap();
    drop_code = 60; step(10);
    drop_code = 59; step(1);
    drop_code = 60;
    step(19); expect_state(1'b0, 2'd0, "R5 count restarted");
    step(1);  expect_state(1'b1, 2'd1, "R5 trip after full delay");
    drop_code = 0; step(1);
    settle_idle();
  endtask

  task automatic t_l1_delay_prog();
    l1_dly_ticks = 5; drop_code = 80;
    step(4); expect_state(1'b0, 2'd0, "R2 short delay before");
    step(1); expect_state(1'b1, 2'd1, "R2 short delay trip");
    drop_code = 0; step(1);
    l1_dly_ticks = 0; drop_code = 80;
    step(1); expect_state(1'b1, 2'd1, "R2 zero delay acts as one");
    drop_code = 0; step(1);
    l1_dly_ticks = 20;
    settle_idle();
  endtask

  task automatic t_level2();
    drop_code = 130;
    step(7); expect_state(1'b0, 2'd0, "R3 l2 before delay");
    step(1); expect_state(1'b1, 2'd2, "R3 l2 trip");
    drop_code = 60; step(1);
    expect_state(1'b0, 2'd0, "R7 l2 release");
    settle_idle();
  endtask

  task automatic t_level3();
    drop_code = 200; rail_code = 400;
    step(2); expect_state(1'b0, 2'd0, "R4 l3 before delay");
    step(1); expect_state(1'b1, 2'd3, "R4 R6 l3 trip");
    rail_code = 700; drop_code = 60; step(1);
    expect_state(1'b0, 2'd0, "R7 l3 release");
    settle_idle();
  endtask

  task automatic t_priority();
    // L1 delay 8 equals L2 delay: both expire together
    l1_dly_ticks = 8; drop_code = 130;
    step(8); expect_state(1'b1, 2'd2, "R6 same-edge priority");
    drop_code = 0; step(1);
    l1_dly_ticks = 20;
    settle_idle();
  endtask

  task automatic t_inhibit();
    l1_inhibit = 1'b1; drop_code = 100;
    step(40); expect_state(1'b0, 2'd0, "R8 l1 inhibited");
    drop_code = 130;
    step(7); expect_state(1'b0, 2'd0, "R8 l2 counting");
    step(1); expect_state(1'b1, 2'd2, "R8 l2 trip while inhibited");
    drop_code = 121; step(3);
    expect_state(1'b1, 2'd2, "R8 no release above l2 threshold");
    drop_code = 120; step(1);
    expect_state(1'b0, 2'd0, "R8 release at l2 threshold");
    drop_code = 0; l1_inhibit = 1'b0;
    settle_idle();
  endtask

  task automatic t_l1_high();
    l1_thr_code = 130; drop_code = 130;
    step(8);  expect_state(1'b0, 2'd0, "R9 l2 floored above l1");
    step(12); expect_state(1'b1, 2'd1, "R9 l1 trips at raised setting");
    drop_code = 130; step(1);
    expect_state(1'b0, 2'd0, "R7 release at raised l1");
    drop_code = 0; step(2);
    drop_code = 131;
    step(7); expect_state(1'b0, 2'd0, "R9 floored l2 counting");
    step(1); expect_state(1'b1, 2'd2, "R9 floored l2 trip");
    drop_code = 0; step(1);
    l1_thr_code = 60;
    settle_idle();
  endtask

  task automatic t_unarmed();
    arm_normal = 1'b0; drop_code = 200; rail_code = 100;
    step(30); expect_state(1'b0, 2'd0, "R10 unarmed no trip");
    arm_normal = 1'b1; step(2);
    arm_normal = 1'b0; step(1);
    arm_normal = 1'b1;
    step(2); expect_state(1'b0, 2'd0, "R10 disarm restarts count");
    step(1); expect_state(1'b1, 2'd3, "R10 trip once rearmed");
    rail_code = 700; drop_code = 0; step(1);
    settle_idle();
  endtask

  task automatic t_tick();
    tick = 1'b0; rail_code = 100;
    step(20); expect_state(1'b0, 2'd0, "R11 no tick no count");
    tick = 1'b1;
    step(2); expect_state(1'b0, 2'd0, "R11 counting on ticks");
    step(1); expect_state(1'b1, 2'd3, "R11 trip after ticks");
    rail_code = 700; drop_code = 0; step(1);
    settle_idle();
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; drop_code = 0; rail_code = 700;
    l1_thr_code = 60; l1_dly_ticks = 20; l1_inhibit = 1'b0; arm_normal = 1'b1;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_level1();
    t_l1_gap();
    t_l1_delay_prog();
    t_level2();
    t_level3();
    t_priority();
    t_inhibit();
    t_l1_high();
    t_unarmed();
    t_tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule